// File: doc/BRIEF.md
# Audio Bit-Clock Ratio Divider

This block derives the timing for a two-channel serial audio port from a single master clock. Three controls pick the frame timing: a 3-bit power-of-two multiplier code, a base-family bit that chooses between ratios built on 512 and ratios built on 384 master clocks per frame, and a wide-frame bit that puts either 32 or 48 bit clocks in each frame. From these the block works out how many master-clock cycles make up one bit. It then produces a square bit clock, a single-cycle strobe at the end of every bit, and a left/right frame clock that changes level in the middle of each frame.

The divider runs only while `runEn` is high and `clkGate` is low. The configuration is captured at the clock edge on which the divider starts and stays frozen while it runs. A combination that does not divide into a whole number of at least two master cycles per bit raises `cfgErr`, and the outputs then stay idle.

Top module: `audclk_ratio_div`

## Requirements
- R1: With `baseSel`=0 and `wide48`=0, `multCode` values 0, 1, 2 and 3 select 512, 256, 128 and 64 master clocks per frame, which gives 16, 8, 4 and 2 master cycles per bit.
- R2: With `baseSel`=1, `multCode` values 0, 1 and 2 select 384, 192 and 96 master clocks per frame. With `wide48`=1 this gives 8, 4 and 2 cycles per bit. With `wide48`=0 it gives 12, 6 and 3.
- R3: A frame holds 32 bits when `wide48`=0 and 48 bits when `wide48`=1. The `frameClk` period is that many bits.
- R4: A combination whose ratio is not a whole multiple of the bits per frame, or which gives fewer than 2 cycles per bit, sets `cfgErr`=1 and keeps all three timing outputs low while the run request is held. Such combinations include `baseSel`=0 with `multCode`=4 or any value from 5 to 7, `baseSel`=0 with `wide48`=1, and `baseSel`=1 with `multCode`=3.
- R5: `frameClk` is low for the first half of each frame (16 or 24 bits) and high for the second half, starting low in the first cycle of a run.
- R6: `bitPulse` is high for exactly the last master cycle of every bit, and `bitClk` is low in the cycle that follows.
- R7: Within each bit of N master cycles, `bitClk` is low for the first floor(N/2) cycles and high for the rest, odd N included.
- R8: When `runEn` falls or `clkGate` rises, all three outputs are low after the next edge. A later start begins again at bit 0 with `frameClk` low.
- R9: Changes to `multCode`, `baseSel` and `wide48` while running have no effect on the outputs or on `cfgErr` until the next start.
- R10: After reset all outputs are low and the captured configuration is code 0, base 0, 32 bits, so `cfgErr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| runEn | input | 1 | Run request |
| clkGate | input | 1 | Clock gate; high stops the divider |
| multCode | input | 3 | Power-of-two multiplier code |
| baseSel | input | 1 | Base family: 0 for 512-based ratios, 1 for 384-based ratios |
| wide48 | input | 1 | 1 for 48 bits per frame, 0 for 32 |
| bitClk | output | 1 | Square bit clock |
| bitPulse | output | 1 | One-cycle strobe in the last master cycle of each bit |
| frameClk | output | 1 | Left/right frame clock |
| cfgErr | output | 1 | Captured configuration cannot be divided |

## Verification
The assertions take for granted that reset is applied before the first edge. They also rely on the control never letting the counters run with fewer than two cycles per bit; that condition is what makes a strobe always followed by a low bit clock. The run, gate and configuration inputs may change in any cycle. The stimulus changes them only on the falling clock edge, so each start is seen on one known rising edge and the reference model can count master cycles from that edge. Bad combinations are driven only as whole configurations on which a start is attempted, or as mid-run changes. In both cases the properties must still hold.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
  typedef struct packed {
    logic clear;
    logic step;
  } divStrobe_t;
endpackage

// File: rtl/audclk_ctrl.sv
module audclk_ctrl
  import audclk_pkg::*;
#(
  parameter int CODE_W      = 3,
  parameter int BASE_A      = 512,
  parameter int BASE_B      = 384,
  parameter int MAX_CODE_A  = 4,
  parameter int MAX_CODE_B  = 3,
  parameter int BITS_NARROW = 32,
  parameter int BITS_WIDE   = 48,
  localparam int DIV_W      = $clog2(BASE_A / BITS_NARROW + 1),
  localparam int BIT_W      = $clog2(BITS_WIDE + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              clkGate,
  input  logic [CODE_W-1:0] multCode,
  input  logic              baseSel,
  input  logic              wide48,
  output divStrobe_t        strobe,
  output logic [DIV_W-1:0]  cpb,
  output logic [BIT_W-1:0]  bpf,
  output logic              cfgErr
);
  logic              running;
  logic [CODE_W-1:0] cfgCode;
  logic              cfgBase;
  logic              cfgWide;
  logic              active;
  logic [DIV_W:0]    inCalc;
  logic [DIV_W:0]    regCalc;

  // Returns {ok, cyclesPerBit}
  function automatic logic [DIV_W:0] calcDiv(input logic [CODE_W-1:0] code,
                                             input logic base, input logic wide);
    int ratio;
    int bits;
    logic ok;
    ratio = 0;
    if (base) begin
      if (int'(code) <= MAX_CODE_B) ratio = BASE_B >> code;
    end else begin
      if (int'(code) <= MAX_CODE_A) ratio = BASE_A >> code;
    end
    bits = wide ? BITS_WIDE : BITS_NARROW;
    ok = (ratio != 0) && (ratio % bits == 0) && (ratio / bits >= 2);
    return {ok, DIV_W'(ratio / bits)};
  endfunction

  assign active  = runEn && !clkGate;
  assign inCalc  = calcDiv(multCode, baseSel, wide48);
  assign regCalc = calcDiv(cfgCode, cfgBase, cfgWide);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      cfgCode <= '0;
      cfgBase <= 1'b0;
      cfgWide <= 1'b0;
    end else begin
      if (!running) begin
        cfgCode <= multCode;
        cfgBase <= baseSel;
        cfgWide <= wide48;
      end
      running <= active && (running || inCalc[DIV_W]);
    end
  end

  assign strobe.clear = !running;
  assign strobe.step  = running;
  assign cpb          = regCalc[DIV_W-1:0];
  assign bpf          = cfgWide ? BIT_W'(BITS_WIDE) : BIT_W'(BITS_NARROW);
  assign cfgErr       = !regCalc[DIV_W];

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(running)) |-> ($stable(cfgCode) && $stable(cfgBase) && $stable(cfgWide)));

  assert_err_blocks_run_R4: assert property (@(posedge clk) disable iff (!rstN)
    running |-> !cfgErr);
endmodule

// File: rtl/audclk_datapath.sv
module audclk_datapath
  import audclk_pkg::*;
#(
  parameter int DIV_W = 5,
  parameter int BIT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobe_t       strobe,
  input  logic [DIV_W-1:0] cpb,
  input  logic [BIT_W-1:0] bpf,
  output logic             bitClk,
  output logic             bitPulse,
  output logic             frameClk
);
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             lastDiv;
  logic             lastBit;

  assign lastDiv = (divCnt == cpb - DIV_W'(1));
  assign lastBit = (bitCnt == bpf - BIT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      bitCnt <= '0;
    end else if (strobe.clear) begin
      divCnt <= '0;
      bitCnt <= '0;
    end else if (strobe.step) begin
      divCnt <= lastDiv ? '0 : divCnt + DIV_W'(1);
      if (lastDiv) bitCnt <= lastBit ? '0 : bitCnt + BIT_W'(1);
    end
  end

  assign bitClk   = strobe.step && (divCnt >= (cpb >> 1));
  assign bitPulse = strobe.step && lastDiv;
  assign frameClk = strobe.step && (bitCnt >= (bpf >> 1));

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    bitPulse |=> !bitPulse);

  assert_pulse_then_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    bitPulse |=> !bitClk);

  assert_clear_counters_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (divCnt == '0 && bitCnt == '0));

  assert_frame_on_boundary_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && $past(strobe.step) && !$stable(frameClk)) |-> $past(bitPulse));
endmodule

// File: rtl/audclk_ratio_div.sv
module audclk_ratio_div
  import audclk_pkg::*;
#(
  parameter int CODE_W      = 3,
  parameter int BASE_A      = 512,
  parameter int BASE_B      = 384,
  parameter int MAX_CODE_A  = 4,
  parameter int MAX_CODE_B  = 3,
  parameter int BITS_NARROW = 32,
  parameter int BITS_WIDE   = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              clkGate,
  input  logic [CODE_W-1:0] multCode,
  input  logic              baseSel,
  input  logic              wide48,
  output logic              bitClk,
  output logic              bitPulse,
  output logic              frameClk,
  output logic              cfgErr
);
  localparam int DIV_W = $clog2(BASE_A / BITS_NARROW + 1);
  localparam int BIT_W = $clog2(BITS_WIDE + 1);

  divStrobe_t       strobe;
  logic [DIV_W-1:0] cpb;
  logic [BIT_W-1:0] bpf;

  audclk_ctrl #(
    .CODE_W(CODE_W), .BASE_A(BASE_A), .BASE_B(BASE_B),
    .MAX_CODE_A(MAX_CODE_A), .MAX_CODE_B(MAX_CODE_B),
    .BITS_NARROW(BITS_NARROW), .BITS_WIDE(BITS_WIDE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .clkGate(clkGate),
    .multCode(multCode), .baseSel(baseSel), .wide48(wide48),
    .strobe(strobe), .cpb(cpb), .bpf(bpf), .cfgErr(cfgErr)
  );

  audclk_datapath #(.DIV_W(DIV_W), .BIT_W(BIT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpb(cpb), .bpf(bpf),
    .bitClk(bitClk), .bitPulse(bitPulse), .frameClk(frameClk)
  );
endmodule

// File: tb/audclk_ratio_div_tb.sv
module audclk_ratio_div_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       runEn = 1'b0;
  logic       clkGate = 1'b0;
  logic [2:0] multCode = '0;
  logic       baseSel = 1'b0;
  logic       wide48 = 1'b0;
  logic       bitClk, bitPulse, frameClk, cfgErr;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  audclk_ratio_div u_dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .clkGate(clkGate),
    .multCode(multCode), .baseSel(baseSel), .wide48(wide48),
    .bitClk(bitClk), .bitPulse(bitPulse), .frameClk(frameClk), .cfgErr(cfgErr)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference: cycles per bit from the requirement tables, 0 when invalid
  function automatic int refCpb(input int code, input bit base, input bit wide);
    int ratio;
    int bits;
    ratio = 0;
    if (base) begin
      if (code <= 3) ratio = 384 >> code;
    end else begin
      if (code <= 4) ratio = 512 >> code;
    end
    bits = wide ? 48 : 32;
    if (ratio == 0 || ratio % bits != 0 || ratio / bits < 2) return 0;
    return ratio / bits;
  endfunction

  task automatic checkCycle(input string tag, input int k, input int cpb, input int bpf);
    int d;
    int b;
    d = k % cpb;
    b = (k / cpb) % bpf;
    check(tag, "bitClk", int'(bitClk), int'(d >= cpb / 2));
    check(tag, "bitPulse", int'(bitPulse), int'(d == cpb - 1));
    check(tag, "frameClk", int'(frameClk), int'(b >= bpf / 2));
  endtask

  task automatic stopAndCheck(input string tag);
    runEn = 1'b0;
    @(negedge clk);
    check(tag, "stopped bitClk", int'(bitClk), 0);
    check(tag, "stopped bitPulse", int'(bitPulse), 0);
    check(tag, "stopped frameClk", int'(frameClk), 0);
  endtask

  // Start a run from a negedge and compare every cycle against the model
  task automatic runScenario(input string tag, input int code, input bit base,
                             input bit wide, input int nCycles);
    int cpb;
    int bpf;
    cpb = refCpb(code, base, wide);
    bpf = wide ? 48 : 32;
    multCode = 3'(code);
    baseSel = base;
    wide48 = wide;
    clkGate = 1'b0;
    runEn = 1'b1;
    for (int k = 0; k < nCycles; k++) begin
      @(negedge clk);
      check(tag, "cfgErr", int'(cfgErr), int'(cpb == 0));
      if (cpb == 0) begin
        check(tag, "idle bitClk", int'(bitClk), 0);
        check(tag, "idle bitPulse", int'(bitPulse), 0);
        check(tag, "idle frameClk", int'(frameClk), 0);
      end else begin
        checkCycle(tag, k, cpb, bpf);
      end
    end
    stopAndCheck("R8");
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R10", "reset bitClk", int'(bitClk), 0);
    check("R10", "reset bitPulse", int'(bitPulse), 0);
    check("R10", "reset frameClk", int'(frameClk), 0);
    check("R10", "reset cfgErr", int'(cfgErr), 0);
  endtask

  task automatic testBaseA();
    for (int c = 0; c < 4; c++) runScenario("R1", c, 1'b0, 1'b0, 2 * 32 * (16 >> c) + 5);
  endtask

  task automatic testBaseB();
    for (int c = 0; c < 3; c++) runScenario("R2", c, 1'b1, 1'b1, 2 * 48 * (8 >> c) + 5);
    runScenario("R2", 0, 1'b1, 1'b0, 2 * 32 * 12 + 5);
    runScenario("R7", 2, 1'b1, 1'b0, 2 * 32 * 3 + 5);
    runScenario("R3", 1, 1'b1, 1'b0, 3 * 32 * 6 + 5);
  endtask

  task automatic testBadConfigs();
    runScenario("R4", 4, 1'b0, 1'b0, 40);
    runScenario("R4", 2, 1'b0, 1'b1, 40);
    runScenario("R4", 3, 1'b1, 1'b1, 40);
    runScenario("R4", 6, 1'b0, 1'b0, 40);
    runScenario("R4", 3, 1'b1, 1'b0, 40);
  endtask

  // Stop by run and by gate mid-frame, then restart from bit 0
  task automatic testStopRestart();
    multCode = 3'd2; baseSel = 1'b0; wide48 = 1'b0; clkGate = 1'b0;
    runEn = 1'b1;
    for (int k = 0; k < 75; k++) begin
      @(negedge clk);
      checkCycle("R5", k, 4, 32);
    end
    clkGate = 1'b1;
    @(negedge clk);
    check("R8", "gated bitClk", int'(bitClk), 0);
    check("R8", "gated bitPulse", int'(bitPulse), 0);
    check("R8", "gated frameClk", int'(frameClk), 0);
    repeat (3) @(negedge clk);
    check("R8", "gated hold bitClk", int'(bitClk), 0);
    clkGate = 1'b0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      checkCycle("R8", k, 4, 32);
    end
    stopAndCheck("R8");
  endtask

  // Mid-run changes to a bad combination must not disturb anything
  task automatic testIgnoreChanges();
    multCode = 3'd1; baseSel = 1'b1; wide48 = 1'b1; clkGate = 1'b0;
    runEn = 1'b1;
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      if (k == 10) begin multCode = 3'd7; baseSel = 1'b0; end
      if (k == 50) wide48 = 1'b0;
      checkCycle("R9", k, 4, 48);
      check("R9", "cfgErr frozen", int'(cfgErr), 0);
    end
    stopAndCheck("R9");
    @(negedge clk);
    check("R9", "cfgErr after stop", int'(cfgErr), 1);
  endtask

  initial begin
    #(1_000_000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBaseA();
    testBaseB();
    testBadConfigs();
    testStopRestart();
    testIgnoreChanges();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule